// File: doc/BRIEF.md
# Banked User Register Access Unit

This block holds the sixteen 32-bit general registers of a processor core together with the extra copies that exist in each privileged mode. An access names a register number from 0 to 15 and supplies the current 5-bit mode field. The register-number and mode fields together select the physical entry. Normal accesses see the registers that belong to the current mode.

A user-view select lets privileged code read or write the register as user mode sees it, whatever mode is current. The stack pointer (R13) and link register (R14) always come from the user bank on such an access. R8 to R12 only differ from the normal path while the core is in fast-interrupt mode, where they are routed to the user copies instead of the fast-interrupt copies. R0 to R7 and the program counter slot R15 are single shared entries.

Reads are combinational on the address and mode inputs. Writes land on the rising clock edge. Exception entry, bank swapping on mode change, and program counter sequencing are handled elsewhere.

Top module: `banked_user_regs`

## Requirements
- R1: R0 to R7 are one shared set: a value written in any mode, through either view, reads back the same in every mode and both views.
- R2: R15 is a single entry shared by every mode and both views.
- R3: A user-view access to R13 always reaches the user-mode stack pointer copy, the one a normal access sees in user mode (5'b10000).
- R4: A user-view access to R14 always reaches the user-mode link copy, the one a normal access sees in user mode (5'b10000).
- R5: In fast-interrupt mode (5'b10001), a user-view access to R8 to R12 reaches the user-mode copies, which are separate from the fast-interrupt copies seen by normal access in that mode.
- R6: In any mode other than fast interrupt, a user-view access to R8 to R12 reaches the same entry as a normal access.
- R7: A normal access uses the bank of the current mode. Fast interrupt (5'b10001) has its own R8 to R14. Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) each have their own R13 and R14. User (5'b10000), system (5'b11111) and every other encoding use the user bank.
- R8: The read data follows the register number, mode and view select in the same cycle, with no clock edge needed.
- R9: A write takes effect at the rising clock edge only when the write enable is high, and changes only the one addressed entry. With the enable low, no entry changes.
- R10: After reset every entry reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_idx | input | 4 | Architectural register number 0 to 15 |
| cpu_mode | input | 5 | Current processor mode field |
| user_view | input | 1 | 1 selects the user-mode view of the register |
| wr_en | input | 1 | Write enable for the addressed entry |
| wr_data | input | 32 | Data written on the clock edge |
| rd_data | output | 32 | Combinational read of the addressed entry |

## Verification
The assertions assume that the register number, mode, view select and write enable are never unknown while reset is released. They also assume that the write data is stable around the rising edge. The bench drives every input at the falling edge and holds it through the next rising edge. It keeps all inputs at defined values from time zero, including during reset. The random phase draws modes from the six banked encodings, the system encoding and arbitrary 5-bit values, so that unlisted encodings also exercise the fall-back to the user bank.

// File: rtl/ubank_pkg.sv
package ubank_pkg;

  localparam int ARCH_REGS  = 16;
  localparam int IDX_W      = $clog2(ARCH_REGS);
  localparam int MODE_W     = 5;

  // first and count of the registers the fast-interrupt mode duplicates
  localparam int HI_FIRST   = 8;
  localparam int HI_COUNT   = 5;
  localparam int SP_IDX     = 13;
  localparam int LR_IDX     = 14;
  localparam int PC_IDX     = 15;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  localparam int NUM_BANKS  = 6;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // physical slot layout
  localparam int SLOT_USR_HI = HI_FIRST;
  localparam int SLOT_FIQ_HI = SLOT_USR_HI + HI_COUNT;
  localparam int SLOT_SPLR   = SLOT_FIQ_HI + HI_COUNT;
  localparam int SLOT_PC     = SLOT_SPLR + 2 * NUM_BANKS;
  localparam int NUM_SLOTS   = SLOT_PC + 1;
  localparam int SLOT_W      = $clog2(NUM_SLOTS);

  function automatic bank_e mode_bank(input logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      MODE_FIQ: b = BANK_FIQ;
      MODE_IRQ: b = BANK_IRQ;
      MODE_SVC: b = BANK_SVC;
      MODE_ABT: b = BANK_ABT;
      MODE_UND: b = BANK_UND;
      default:  b = BANK_USR;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ubank_rst_sync.sv
module ubank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ubank_slot_map.sv
module ubank_slot_map
  import ubank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              user_view,
  output logic [SLOT_W-1:0] slot
);

  bank_e cur_bank;
  bank_e eff_bank;
  int    slot_int;

  always_comb begin
    cur_bank = mode_bank(cpu_mode);
    // user view forces the user bank for the stack and link registers
    eff_bank = user_view ? BANK_USR : cur_bank;
  end

  always_comb begin
    slot_int = 0;
    if (int'(reg_idx) < HI_FIRST) begin
      slot_int = int'(reg_idx);
    end else if (int'(reg_idx) < SP_IDX) begin
      if (cur_bank == BANK_FIQ && !user_view) begin
        slot_int = SLOT_FIQ_HI + int'(reg_idx) - HI_FIRST;
      end else begin
        slot_int = SLOT_USR_HI + int'(reg_idx) - HI_FIRST;
      end
    end else if (int'(reg_idx) < PC_IDX) begin
      slot_int = SLOT_SPLR + 2 * int'(eff_bank) + int'(reg_idx) - SP_IDX;
    end else begin
      slot_int = SLOT_PC;
    end
  end

  assign slot = SLOT_W'(slot_int);

  // R1
  low_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx < 4'd8) |-> (slot == SLOT_W'(reg_idx)));

  // R2
  pc_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 4'd15) |-> (slot == SLOT_W'(SLOT_PC)));

  // R3
  user_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_view && reg_idx == 4'd13) |-> (slot == SLOT_W'(SLOT_SPLR)));

  // R4
  user_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_view && reg_idx == 4'd14) |-> (slot == SLOT_W'(SLOT_SPLR + 1)));

  // R6
  hi_nonfiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mode != MODE_FIQ && reg_idx >= 4'd8 && reg_idx <= 4'd12)
      |-> (slot < SLOT_W'(SLOT_FIQ_HI)));

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot < SLOT_W'(NUM_SLOTS));

endmodule

// File: rtl/ubank_storage.sv
module ubank_storage
  import ubank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0]    regs_q [NUM_SLOTS];
  logic [DATA_W-1:0]    regs_d [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_we;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      slot_we[i] = wr_en && (slot == SLOT_W'(i));
      regs_d[i]  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        regs_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (slot_we[i]) begin
          regs_q[i] <= regs_d[i];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot == SLOT_W'(i)) begin
        rd_data = regs_q[i];
      end
    end
  end

  // R9
  single_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_we) <= 1);

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_chk
      // R9
      held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_we[g] |=> $stable(regs_q[g]));
      // R9
      written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_we[g] |=> (regs_q[g] == $past(wr_data)));
    end
  endgenerate

endmodule

// File: rtl/banked_user_regs.sv
module banked_user_regs
  import ubank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_idx,
  input  logic [4:0]        cpu_mode,
  input  logic              user_view,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic              rst_n_sync;
  logic [SLOT_W-1:0] slot;

  ubank_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ubank_slot_map u_slot_map (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .reg_idx   (reg_idx),
    .cpu_mode  (cpu_mode),
    .user_view (user_view),
    .slot      (slot)
  );

  ubank_storage #(
    .DATA_W (DATA_W)
  ) u_storage (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .slot    (slot),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

endmodule

// File: tb/banked_user_regs_tb.sv
module banked_user_regs_tb;

  logic        clk;
  logic        rst_n;
  logic [3:0]  reg_idx;
  logic [4:0]  cpu_mode;
  logic        user_view;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;

  int checks;
  int fails;
  bit done;

  // behavioural reference state
  logic [31:0] m_usr [16];
  logic [31:0] m_fiq [16];
  logic [31:0] m_bk  [6][2];

  banked_user_regs u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .cpu_mode  (cpu_mode),
    .user_view (user_view),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  function automatic int kind_of(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_read(input int r, input logic [4:0] m, input bit uv);
    int k;
    k = kind_of(m);
    if (r < 8 || r == 15) return m_usr[r];
    if (r < 13) return (k == 1 && !uv) ? m_fiq[r] : m_usr[r];
    if (uv || k == 0) return m_usr[r];
    if (k == 1) return m_fiq[r];
    return m_bk[k][r-13];
  endfunction

  task automatic ref_write(input int r, input logic [4:0] m, input bit uv, input logic [31:0] d);
    int k;
    k = kind_of(m);
    if (r < 8 || r == 15) m_usr[r] = d;
    else if (r < 13) begin
      if (k == 1 && !uv) m_fiq[r] = d; else m_usr[r] = d;
    end else if (uv || k == 0) m_usr[r] = d;
    else if (k == 1) m_fiq[r] = d;
    else m_bk[k][r-13] = d;
  endtask

  task automatic step(input int r, input logic [4:0] m, input bit uv, input bit we,
                      input logic [31:0] d, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    reg_idx   = 4'(r);
    cpu_mode  = m;
    user_view = uv;
    wr_en     = we;
    wr_data   = d;
    #1ns;
    exp = ref_read(r, m, uv);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: r%0d mode=%b uv=%0d actual=%h expected=%h", tag, r, m, uv, rd_data, exp);
    end
    @(posedge clk);
    if (we) ref_write(r, m, uv, d);
  endtask

  task automatic rd(input int r, input logic [4:0] m, input bit uv, input string tag);
    step(r, m, uv, 1'b0, 32'hDEAD_0000 ^ 32'(r), tag);
  endtask

  task automatic wr(input int r, input logic [4:0] m, input bit uv, input logic [31:0] d, input string tag);
    step(r, m, uv, 1'b1, d, tag);
  endtask

  localparam logic [4:0] MODES [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                      5'b10111, 5'b11011, 5'b11111};

  initial begin
    #800us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9: watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    done   = 0;
    for (int i = 0; i < 16; i++) begin m_usr[i] = '0; m_fiq[i] = '0; end
    for (int b = 0; b < 6; b++) begin m_bk[b][0] = '0; m_bk[b][1] = '0; end
    rst_n = 1'b0; reg_idx = '0; cpu_mode = 5'b10000; user_view = 0; wr_en = 0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: every register in every view reads zero after reset
    for (int mi = 0; mi < 7; mi++)
      for (int r = 0; r < 16; r++) rd(r, MODES[mi], r[0], "R10");

    // R1: low registers shared
    wr(3, 5'b10011, 0, 32'h1111_0003, "R1");
    rd(3, 5'b10000, 0, "R1");
    rd(3, 5'b10001, 1, "R1");
    wr(7, 5'b10001, 1, 32'h1111_0007, "R1");
    rd(7, 5'b11011, 0, "R1");

    // R2: program counter slot shared
    wr(15, 5'b10010, 1, 32'h2222_000F, "R2");
    rd(15, 5'b10001, 0, "R2");
    rd(15, 5'b10000, 1, "R2");

    // R7: per-mode stack and link copies
    for (int mi = 0; mi < 6; mi++) begin
      wr(13, MODES[mi], 0, 32'h7000_0D00 + 32'(mi), "R7");
      wr(14, MODES[mi], 0, 32'h7000_0E00 + 32'(mi), "R7");
    end
    for (int mi = 0; mi < 7; mi++) begin
      rd(13, MODES[mi], 0, "R7");
      rd(14, MODES[mi], 0, "R7");
    end
    rd(13, 5'b10101, 0, "R7");
    rd(14, 5'b00000, 0, "R7");

    // R3 / R4: user view reaches the user stack and link in every mode
    for (int mi = 0; mi < 7; mi++) begin
      wr(13, MODES[mi], 1, 32'h3300_0000 + 32'(mi), "R3");
      rd(13, 5'b10000, 0, "R3");
      rd(13, MODES[mi], 0, "R3");
      wr(14, MODES[mi], 1, 32'h4400_0000 + 32'(mi), "R4");
      rd(14, 5'b10000, 0, "R4");
      rd(14, MODES[mi], 0, "R4");
    end

    // R5: fast-interrupt user view of R8..R12
    for (int r = 8; r <= 12; r++) begin
      wr(r, 5'b10001, 0, 32'h5F00_0000 + 32'(r), "R5");
      wr(r, 5'b10001, 1, 32'h5A00_0000 + 32'(r), "R5");
    end
    for (int r = 8; r <= 12; r++) begin
      rd(r, 5'b10001, 0, "R5");
      rd(r, 5'b10001, 1, "R5");
      rd(r, 5'b10000, 0, "R5");
    end

    // R6: outside fast interrupt both views agree
    wr(10, 5'b10010, 1, 32'h6600_000A, "R6");
    rd(10, 5'b10010, 0, "R6");
    wr(9, 5'b10011, 0, 32'h6600_0009, "R6");
    rd(9, 5'b10011, 1, "R6");
    rd(9, 5'b11111, 1, "R6");

    // R8: read follows address in the same cycle, consecutive distinct reads
    for (int r = 0; r < 16; r++) rd(r, 5'b10001, 0, "R8");

    // R9: enable low leaves every entry untouched
    for (int r = 0; r < 16; r++) step(r, 5'b10011, 0, 1'b0, 32'hBAD0_0000 + 32'(r), "R9");
    for (int r = 0; r < 16; r++) rd(r, 5'b10011, 0, "R9");
    for (int r = 8; r < 15; r++) rd(r, 5'b10001, 0, "R9");

    // R9: random mix across modes, views and unlisted encodings
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] m;
      m = ($urandom_range(0, 7) == 7) ? 5'($urandom) : MODES[$urandom_range(0, 6)];
      step($urandom_range(0, 15), m, 1'($urandom), 1'($urandom), $urandom, "R9");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule